// File: doc/BRIEF.md
# Memory-Mapped I/O Bus Bridge

This block sits between a processor's load/store port and two targets: a word-organised data memory and a small set of board peripherals. Every access from the core is steered by its address. Addresses at or above the I/O window base (0xfffffc00) reach peripheral registers. All lower addresses reach memory, with byte-lane enables and lane-replicated write data. Read data goes back to the core with byte or halfword extension already applied. The core therefore sees one uniform data port and needs no knowledge of which target answered.

Loads from the I/O window return the live state of the slide switches and push buttons. Stores into the window update holding registers for two LED groups and for two seven-segment display values. Peripheral reads accept only byte or halfword accesses. Peripheral writes accept only byte or word accesses. An access of any other size to the window, or any access to an address in the window that is not mapped, reads as zero and changes no register. Switch debouncing and display multiplexing belong to other blocks.

Top module: `mmio_bridge`

## Requirements
- R1: An address below 0xfffffc00 goes to memory: `mem_we` follows `cpu_we` and `mem_addr` equals address bits [15:2]. An address at or above 0xfffffc00 holds `mem_we` low.
- R2: Memory loads use size code 2'b00 for byte, 2'b01 for halfword, 2'b10 for word, and 2'b11 behaves as word. A byte load takes lane `addr[1:0]`, with lane 0 at bits [7:0]. A halfword load takes bits [31:16] when `addr[1]` is 1, else bits [15:0]. Byte and halfword loads are sign-extended when `load_signed` is 1 and zero-extended otherwise. A word load passes the data unchanged.
- R3: A load from 0xfffffc00 returns all 16 switch bits. A load from 0xfffffc10 returns switch bits [15:8] in result bits [7:0].
- R4: A load from 0xfffffc20 + 2*i returns button i in bit 0, for i = 0..3.
- R5: An I/O byte load takes the low 8 bits of the peripheral value and extends them according to `load_signed`. An I/O halfword load returns the low 16 bits, zero-extended. An I/O word-size load returns zero.
- R6: At the clock edge after a store, the data is written to the target register: 0xfffffc40 writes `led_all` (16 bits), 0xfffffc60 writes `led_right` (8 bits), 0xfffffc69 writes `seg_wide` (32 bits) and 0xfffffc70 writes `seg_narrow` (16 bits). A byte store writes `cpu_wdata[7:0]`, zero-extended. A word store writes the low bits of `cpu_wdata`.
- R7: A halfword store to the I/O window, or a store to an unmapped I/O address (compared on all 32 bits), changes no output register. A load from an unmapped I/O address returns zero.
- R8: Reset clears all output registers. Each register then holds its value until a store to its own address.
- R9: When `mem_we` is 1, `mem_be` equals 1<<addr[1:0] for a byte store, 4'b0011 or 4'b1100 (by `addr[1]`) for a halfword store, and 4'b1111 for a word store. When `mem_we` is 0, `mem_be` is 0. `mem_wdata` repeats the byte in all four lanes for a byte store, repeats the halfword in both halves for a halfword store, and passes `cpu_wdata` unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 32 | Byte address from the core |
| cpu_wdata | input | 32 | Store data from the core |
| cpu_we | input | 1 | Store strobe |
| acc_size | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| load_signed | input | 1 | 1 = sign-extend narrow loads |
| cpu_rdata | output | 32 | Extended load data to the core |
| mem_addr | output | 14 | Word index into data memory |
| mem_wdata | output | 32 | Lane-replicated memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_rdata | input | 32 | Word read from memory |
| switches | input | 16 | Slide switch levels |
| buttons | input | 4 | Push button levels |
| led_all | output | 16 | Full LED group register |
| led_right | output | 8 | Right LED group register |
| seg_wide | output | 32 | 32-bit display value register |
| seg_narrow | output | 16 | 16-bit display value register |

## Verification
If the window decode goes wrong, the fault shows in the same cycle. A store that should reach a peripheral also raises `mem_we`, and it corrupts memory the moment the memory samples it. A load picks the wrong source and `cpu_rdata` is wrong at once. A bad lane select or extension shows immediately as a wrong byte position or a wrong upper fill in `cpu_rdata`. A register that captures the wrong data, or that captures when it should not, is visible one edge after the store. After that it stays wrong on its output pins until the next store to that address. The bench therefore checks the combinational paths within the same cycle, and checks the registers one edge after each store and again after stores to other addresses.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   localparam logic [31:0] ADR_SW_ALL     = 32'hFFFF_FC00;
   localparam logic [31:0] ADR_SW_LEFT    = 32'hFFFF_FC10;
   localparam logic [31:0] ADR_BTN_BASE   = 32'hFFFF_FC20;
   localparam logic [31:0] ADR_BTN_STEP   = 32'd2;
   localparam logic [31:0] ADR_LED_ALL    = 32'hFFFF_FC40;
   localparam logic [31:0] ADR_LED_RIGHT  = 32'hFFFF_FC60;
   localparam logic [31:0] ADR_SEG_WIDE   = 32'hFFFF_FC69;
   localparam logic [31:0] ADR_SEG_NARROW = 32'hFFFF_FC70;

   function automatic logic [31:0] extend8(input logic [7:0] v, input logic sgn);
      return {{24{sgn & v[7]}}, v};
   endfunction

   function automatic logic [31:0] extend16(input logic [15:0] v, input logic sgn);
      return {{16{sgn & v[15]}}, v};
   endfunction
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode #(
   parameter logic [31:0] IO_BASE = 32'hFFFF_FC00,
   parameter int          BTN_N   = 4
) (
   input  logic [31:0]      addr,
   output logic             io_hit,
   output logic             sel_sw_all,
   output logic             sel_sw_left,
   output logic [BTN_N-1:0] sel_btn,
   output logic             sel_led_all,
   output logic             sel_led_right,
   output logic             sel_seg_wide,
   output logic             sel_seg_narrow
);
   import mmio_pkg::*;

   assign io_hit         = (addr >= IO_BASE);
   assign sel_sw_all     = (addr == ADR_SW_ALL);
   assign sel_sw_left    = (addr == ADR_SW_LEFT);
   assign sel_led_all    = (addr == ADR_LED_ALL);
   assign sel_led_right  = (addr == ADR_LED_RIGHT);
   assign sel_seg_wide   = (addr == ADR_SEG_WIDE);
   assign sel_seg_narrow = (addr == ADR_SEG_NARROW);

   for (genvar gi = 0; gi < BTN_N; gi++) begin : g_btn
      localparam logic [31:0] BTN_ADR = ADR_BTN_BASE + ADR_BTN_STEP * 32'(gi);
      assign sel_btn[gi] = (addr == BTN_ADR);
   end
endmodule

// File: rtl/mmio_load_path.sv
module mmio_load_path #(
   parameter int SW_W  = 16,
   parameter int BTN_N = 4
) (
   input  logic             io_hit,
   input  logic             sel_sw_all,
   input  logic             sel_sw_left,
   input  logic [BTN_N-1:0] sel_btn,
   input  logic [1:0]       acc_size,
   input  logic             load_signed,
   input  logic [1:0]       lane,
   input  logic [31:0]      mem_rdata,
   input  logic [SW_W-1:0]  switches,
   input  logic [BTN_N-1:0] buttons,
   output logic [31:0]      rdata
);
   import mmio_pkg::*;

   logic [31:0] io_raw;
   logic [31:0] io_val;
   logic [31:0] mem_val;
   logic        btn_bit;

   assign btn_bit = |(sel_btn & buttons);

   always_comb begin
      io_raw = '0;
      if (sel_sw_all)
         io_raw = 32'(switches);
      else if (sel_sw_left)
         io_raw = {24'b0, switches[SW_W-1 -: 8]};
      else if (|sel_btn)
         io_raw = {31'b0, btn_bit};
   end

   always_comb begin
      unique case (acc_size_e'(acc_size))
         SZ_BYTE: io_val = extend8(io_raw[7:0], load_signed);
         SZ_HALF: io_val = extend16(io_raw[15:0], 1'b0);
         default: io_val = '0;
      endcase
   end

   always_comb begin
      unique case (acc_size_e'(acc_size))
         SZ_BYTE: mem_val = extend8(mem_rdata[8*lane +: 8], load_signed);
         SZ_HALF: mem_val = extend16(lane[1] ? mem_rdata[31:16] : mem_rdata[15:0],
                                     load_signed);
         default: mem_val = mem_rdata;
      endcase
   end

   assign rdata = io_hit ? io_val : mem_val;
endmodule

// File: rtl/mmio_store_path.sv
module mmio_store_path (
   input  logic        io_hit,
   input  logic        cpu_we,
   input  logic [1:0]  acc_size,
   input  logic [1:0]  lane,
   input  logic [31:0] cpu_wdata,
   output logic        mem_we,
   output logic [3:0]  mem_be,
   output logic [31:0] mem_wdata,
   output logic [31:0] io_wval,
   output logic        io_size_ok
);
   import mmio_pkg::*;

   logic [3:0] lanes;

   assign mem_we = cpu_we & ~io_hit;

   always_comb begin
      unique case (acc_size_e'(acc_size))
         SZ_BYTE: begin
            lanes     = 4'b0001 << lane;
            mem_wdata = {4{cpu_wdata[7:0]}};
         end
         SZ_HALF: begin
            lanes     = lane[1] ? 4'b1100 : 4'b0011;
            mem_wdata = {2{cpu_wdata[15:0]}};
         end
         default: begin
            lanes     = 4'b1111;
            mem_wdata = cpu_wdata;
         end
      endcase
   end

   assign mem_be     = mem_we ? lanes : 4'b0000;
   assign io_size_ok = (acc_size_e'(acc_size) != SZ_HALF);
   assign io_wval    = (acc_size_e'(acc_size) == SZ_BYTE) ? {24'b0, cpu_wdata[7:0]}
                                                          : cpu_wdata;
endmodule

// File: rtl/mmio_out_reg.sv
module mmio_out_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge #(
   parameter logic [31:0] IO_BASE = 32'hFFFF_FC00,
   parameter int MEM_AW  = 14,
   parameter int SW_W    = 16,
   parameter int BTN_N   = 4,
   parameter int LEDA_W  = 16,
   parameter int LEDR_W  = 8,
   parameter int SEGW_W  = 32,
   parameter int SEGN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cpu_addr,
   input  logic [31:0]       cpu_wdata,
   input  logic              cpu_we,
   input  logic [1:0]        acc_size,
   input  logic              load_signed,
   output logic [31:0]       cpu_rdata,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   input  logic [31:0]       mem_rdata,
   input  logic [SW_W-1:0]   switches,
   input  logic [BTN_N-1:0]  buttons,
   output logic [LEDA_W-1:0] led_all,
   output logic [LEDR_W-1:0] led_right,
   output logic [SEGW_W-1:0] seg_wide,
   output logic [SEGN_W-1:0] seg_narrow
);
   localparam int MAX_BTN = 16;

   if (MEM_AW < 1 || MEM_AW > 30) begin : g_bad_aw
      $error("mmio_bridge: MEM_AW out of range");
   end
   if (SW_W < 8 || SW_W > 16) begin : g_bad_sw
      $error("mmio_bridge: SW_W must lie in 8..16");
   end
   if (BTN_N < 1 || BTN_N > MAX_BTN) begin : g_bad_btn
      $error("mmio_bridge: BTN_N out of range");
   end
   if (LEDA_W < 8 || LEDA_W > 32 || LEDR_W < 8 || LEDR_W > 32 ||
       SEGW_W < 8 || SEGW_W > 32 || SEGN_W < 8 || SEGN_W > 32) begin : g_bad_out
      $error("mmio_bridge: output register widths must lie in 8..32");
   end

   logic             io_hit;
   logic             sel_sw_all, sel_sw_left;
   logic [BTN_N-1:0] sel_btn;
   logic             sel_led_all, sel_led_right, sel_seg_wide, sel_seg_narrow;
   logic [31:0]      io_wval;
   logic             io_size_ok;
   logic             io_store;

   mmio_decode #(.IO_BASE(IO_BASE), .BTN_N(BTN_N)) i_decode (
      .addr           (cpu_addr),
      .io_hit         (io_hit),
      .sel_sw_all     (sel_sw_all),
      .sel_sw_left    (sel_sw_left),
      .sel_btn        (sel_btn),
      .sel_led_all    (sel_led_all),
      .sel_led_right  (sel_led_right),
      .sel_seg_wide   (sel_seg_wide),
      .sel_seg_narrow (sel_seg_narrow)
   );

   mmio_load_path #(.SW_W(SW_W), .BTN_N(BTN_N)) i_load (
      .io_hit      (io_hit),
      .sel_sw_all  (sel_sw_all),
      .sel_sw_left (sel_sw_left),
      .sel_btn     (sel_btn),
      .acc_size    (acc_size),
      .load_signed (load_signed),
      .lane        (cpu_addr[1:0]),
      .mem_rdata   (mem_rdata),
      .switches    (switches),
      .buttons     (buttons),
      .rdata       (cpu_rdata)
   );

   mmio_store_path i_store (
      .io_hit     (io_hit),
      .cpu_we     (cpu_we),
      .acc_size   (acc_size),
      .lane       (cpu_addr[1:0]),
      .cpu_wdata  (cpu_wdata),
      .mem_we     (mem_we),
      .mem_be     (mem_be),
      .mem_wdata  (mem_wdata),
      .io_wval    (io_wval),
      .io_size_ok (io_size_ok)
   );

   assign mem_addr = cpu_addr[MEM_AW+1:2];
   assign io_store = cpu_we & io_hit & io_size_ok;

   mmio_out_reg #(.W(LEDA_W)) i_led_all (
      .clk (clk), .rst_n (rst_n), .load (io_store & sel_led_all),
      .d (io_wval[LEDA_W-1:0]), .q (led_all)
   );
   mmio_out_reg #(.W(LEDR_W)) i_led_right (
      .clk (clk), .rst_n (rst_n), .load (io_store & sel_led_right),
      .d (io_wval[LEDR_W-1:0]), .q (led_right)
   );
   mmio_out_reg #(.W(SEGW_W)) i_seg_wide (
      .clk (clk), .rst_n (rst_n), .load (io_store & sel_seg_wide),
      .d (io_wval[SEGW_W-1:0]), .q (seg_wide)
   );
   mmio_out_reg #(.W(SEGN_W)) i_seg_narrow (
      .clk (clk), .rst_n (rst_n), .load (io_store & sel_seg_narrow),
      .d (io_wval[SEGN_W-1:0]), .q (seg_narrow)
   );
endmodule

// File: rtl/mmio_bridge_chk.sv
module mmio_bridge_chk #(
   parameter logic [31:0] IO_BASE = 32'hFFFF_FC00,
   parameter int LEDA_W = 16,
   parameter int SEGN_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       cpu_addr,
   input logic [31:0]       cpu_wdata,
   input logic              cpu_we,
   input logic [1:0]        acc_size,
   input logic [31:0]       cpu_rdata,
   input logic              mem_we,
   input logic [3:0]        mem_be,
   input logic [LEDA_W-1:0] led_all,
   input logic [SEGN_W-1:0] seg_narrow
);
   import mmio_pkg::*;

   AST_IO_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= IO_BASE) |-> !mem_we); // R1
   AST_MEM_STORE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < IO_BASE && cpu_we) |-> (mem_we && mem_be != 4'b0000)); // R1
   AST_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |-> (mem_be == 4'b0000)); // R9
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && acc_size == SZ_BYTE) |-> ($countones(mem_be) == 1)); // R9
   AST_IO_WORD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= IO_BASE && acc_size[1]) |-> (cpu_rdata == 32'h0)); // R5
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && cpu_addr == ADR_LED_ALL) |=> $stable(led_all)); // R8
   AST_HALF_STORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr == ADR_LED_ALL && acc_size == SZ_HALF) |=> $stable(led_all)); // R7
   AST_NARROW_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr == ADR_SEG_NARROW && acc_size == SZ_WORD)
      |=> (seg_narrow == $past(cpu_wdata[SEGN_W-1:0]))); // R6
endmodule

bind mmio_bridge mmio_bridge_chk #(.IO_BASE(IO_BASE), .LEDA_W(LEDA_W), .SEGN_W(SEGN_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .cpu_we     (cpu_we),
   .acc_size   (acc_size),
   .cpu_rdata  (cpu_rdata),
   .mem_we     (mem_we),
   .mem_be     (mem_be),
   .led_all    (led_all),
   .seg_narrow (seg_narrow)
);

// File: tb/test_mmio_bridge.sv
module test_mmio_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0, mem_rdata = '0;
   logic        cpu_we = 1'b0, load_signed = 1'b0;
   logic [1:0]  acc_size = 2'b10;
   logic [15:0] switches = '0;
   logic [3:0]  buttons = '0;
   logic [31:0] cpu_rdata, mem_wdata, seg_wide;
   logic [13:0] mem_addr;
   logic        mem_we;
   logic [3:0]  mem_be;
   logic [15:0] led_all, seg_narrow;
   logic [7:0]  led_right;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mmio_bridge i_mmio_bridge (
      .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
      .cpu_we (cpu_we), .acc_size (acc_size), .load_signed (load_signed),
      .cpu_rdata (cpu_rdata), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_we (mem_we), .mem_be (mem_be), .mem_rdata (mem_rdata),
      .switches (switches), .buttons (buttons), .led_all (led_all),
      .led_right (led_right), .seg_wide (seg_wide), .seg_narrow (seg_narrow)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  size;
      logic        sgn;
      logic        we;
      logic [31:0] wdata;
      logic [31:0] mrd;
      logic [15:0] sw;
      logic [3:0]  btn;
      logic [31:0] exp_rd;
      logic        exp_we;
      logic [3:0]  exp_be;
      logic [31:0] exp_wd;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VT [NV] = '{
      // R2 memory loads, memory word 8765F0E1
      '{32'h0000_0100, 2'b10, 1'b0, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'h8765_F0E1, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0101, 2'b00, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'hFFFF_FFF0, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0101, 2'b00, 1'b0, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'h0000_00F0, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0103, 2'b00, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'hFFFF_FF87, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0100, 2'b00, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'hFFFF_FFE1, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0102, 2'b00, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'h0000_0065, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0102, 2'b01, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'hFFFF_8765, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0102, 2'b01, 1'b0, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'h0000_8765, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0100, 2'b01, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'hFFFF_F0E1, 1'b0, 4'h0, 32'h0},
      '{32'h0000_0104, 2'b11, 1'b1, 1'b0, 32'h0, 32'h8765_F0E1, 16'h0, 4'h0, 32'h8765_F0E1, 1'b0, 4'h0, 32'h0},
      // R3 R5 switch reads, memory data nonzero to prove the I/O source wins
      '{32'hFFFF_FC00, 2'b01, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'h0000_A5C3, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC00, 2'b00, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'hFFFF_FFC3, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC00, 2'b00, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'h0000_00C3, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC00, 2'b10, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC10, 2'b00, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'hFFFF_FFA5, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC10, 2'b01, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hA5C3, 4'h0, 32'h0000_00A5, 1'b0, 4'h0, 32'h0},
      // R4 buttons 1010
      '{32'hFFFF_FC20, 2'b00, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hA, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC22, 2'b00, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hA, 32'h0000_0001, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC24, 2'b01, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hA, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC26, 2'b01, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hA, 32'h0000_0001, 1'b0, 4'h0, 32'h0},
      // R7 unmapped I/O reads
      '{32'hFFFF_FC30, 2'b01, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hF, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC21, 2'b00, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hF, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      '{32'hFFFF_FC04, 2'b00, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 16'hFFFF, 4'hF, 32'h0000_0000, 1'b0, 4'h0, 32'h0},
      // R1 R9 memory stores, plus a store into the window
      '{32'h0000_0202, 2'b00, 1'b0, 1'b1, 32'h0000_00AB, 32'h0, 16'h0, 4'h0, 32'h0, 1'b1, 4'b0100, 32'hABAB_ABAB},
      '{32'h0000_0202, 2'b01, 1'b0, 1'b1, 32'h0000_1234, 32'h0, 16'h0, 4'h0, 32'h0, 1'b1, 4'b1100, 32'h1234_1234},
      '{32'h0000_0204, 2'b10, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, 16'h0, 4'h0, 32'h0, 1'b1, 4'b1111, 32'hDEAD_BEEF},
      '{32'hFFFF_FC40, 2'b00, 1'b0, 1'b1, 32'h0000_0077, 32'h0, 16'h0, 4'h0, 32'h0, 1'b0, 4'b0000, 32'h7777_7777},
      '{32'hFFFF_FBFC, 2'b10, 1'b0, 1'b1, 32'h0102_0304, 32'h0, 16'h0, 4'h0, 32'h0, 1'b1, 4'b1111, 32'h0102_0304}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      cpu_addr = a; acc_size = sz; cpu_wdata = d; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0; cpu_addr = 32'h0; cpu_wdata = 32'h0;
   endtask

   task automatic chk_outs(input string req, input logic [15:0] la, input logic [7:0] lr,
                           input logic [31:0] sw_, input logic [15:0] sn);
      chk({req, " led_all"},    32'(led_all),    32'(la));
      chk({req, " led_right"},  32'(led_right),  32'(lr));
      chk({req, " seg_wide"},   seg_wide,        sw_);
      chk({req, " seg_narrow"}, 32'(seg_narrow), 32'(sn));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_outs("R8 reset", 16'h0, 8'h0, 32'h0, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cpu_addr = VT[i].addr; acc_size = VT[i].size; load_signed = VT[i].sgn;
         cpu_we = VT[i].we; cpu_wdata = VT[i].wdata; mem_rdata = VT[i].mrd;
         switches = VT[i].sw; buttons = VT[i].btn;
         #1;
         chk("R2 R3 R4 R5 R7 rdata", cpu_rdata, VT[i].exp_rd);
         chk("R1 mem_we", 32'(mem_we), 32'(VT[i].exp_we));
         chk("R1 mem_addr", 32'(mem_addr), 32'(VT[i].addr[15:2]));
         chk("R9 mem_be", 32'(mem_be), 32'(VT[i].exp_be));
         chk("R9 mem_wdata", mem_wdata, VT[i].exp_wd);
      end
      @(negedge clk);
      cpu_we = 1'b0; cpu_addr = 32'h0;
      @(negedge clk);
      chk_outs("R6 store in vector walk", 16'h0077, 8'h0, 32'h0, 16'h0);

      // R6 byte and word stores to each target
      store(32'hFFFF_FC40, 2'b00, 32'h1234_56F7);
      chk_outs("R6 byte led_all", 16'h00F7, 8'h0, 32'h0, 16'h0);
      store(32'hFFFF_FC40, 2'b10, 32'hDEAD_BEEF);
      chk_outs("R6 word led_all", 16'hBEEF, 8'h0, 32'h0, 16'h0);
      store(32'hFFFF_FC60, 2'b10, 32'h1122_3344);
      chk_outs("R6 word led_right", 16'hBEEF, 8'h44, 32'h0, 16'h0);
      store(32'hFFFF_FC69, 2'b00, 32'hCAFE_BA99);
      chk_outs("R6 byte seg_wide", 16'hBEEF, 8'h44, 32'h0000_0099, 16'h0);
      store(32'hFFFF_FC69, 2'b10, 32'hCAFE_BA99);
      chk_outs("R6 word seg_wide", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0);
      store(32'hFFFF_FC70, 2'b10, 32'h0BAD_F00D);
      chk_outs("R6 word seg_narrow", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'hF00D);
      store(32'hFFFF_FC70, 2'b00, 32'h0000_0181);
      chk_outs("R6 byte seg_narrow", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);

      // R7 ignored stores
      store(32'hFFFF_FC40, 2'b01, 32'h0000_5555);
      chk_outs("R7 half store", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);
      store(32'hFFFF_FC44, 2'b10, 32'h5555_5555);
      chk_outs("R7 unmapped store", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);
      store(32'hFFFF_FC6A, 2'b10, 32'h5555_5555);
      chk_outs("R7 near-miss store", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);

      // R8 hold across a memory store aliasing the low address bits
      store(32'h0000_FC40, 2'b10, 32'h6666_6666);
      chk_outs("R8 hold", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);
      @(negedge clk);
      cpu_addr = 32'hFFFF_FC40; acc_size = 2'b10; cpu_wdata = 32'h7777_7777; cpu_we = 1'b0;
      @(negedge clk);
      chk_outs("R8 no strobe", 16'hBEEF, 8'h44, 32'hCAFE_BA99, 16'h0081);

      // R8 reset clears again
      rst_n = 1'b0;
      #1;
      chk_outs("R8 second reset", 16'h0, 8'h0, 32'h0, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule